// File: doc/BRIEF.md
# Indirect PHY Test-Register Bridge

This block sits between a simple 32-bit register bus and the narrow test port of one or two PHY instances. Each PHY holds a small bank of 8-bit configuration registers that cannot be reached directly. Software reaches them by writing a command word that carries a register index, a data byte and a write-enable flag. It then reads the result back through a second word.

Each PHY instance owns one 16-bit half of the command word and one half of the readback word, so two banks can be programmed side by side through the same bus locations. A bank register changes only when the write-enable flag goes from low to high. Software therefore commits a value in three steps: it writes the value with the flag low, then with the flag high, then with the flag low again. The readback word lags by one read. The first read after any command write returns the old value, and the next read returns the addressed register. The bridge also holds a port-select field and drives the PHY reset. The reset stays asserted unless software has chosen manual control and released it.

Top module: `phy_test_bridge`

## Requirements
- R1: After system reset, every bank register, the command word, the readback word, the port-select field and the reset controls are zero. `phy_reset_n` is low and `port_sel` is 0.
- R2: The command word is at offset 0x2000. For PHY 0, bit 0 is write-enable, bits 5:1 are the register index and bits 13:6 are the data byte. Reading it returns the last value written to the lanes that are present, and zero in every other bit.
- R3: A bank register is written with the command's data byte only when a command write sets write-enable to 1 while the stored write-enable is 0. A command write with write-enable 0, or one that repeats write-enable 1, leaves the bank unchanged.
- R4: The readback word is at offset 0x2004, with PHY 0's addressed register in bits 7:0. The first read after a command write returns the previous readback value, and every later read returns the register selected by the current command. Unused bits read zero.
- R5: PHY 1 uses the same layout shifted up by 16 bits: command bits 29:16 and readback bits 23:16. It operates independently of PHY 0.
- R6: With `NUM_PHY` = 1, command bits 31:14 are ignored and read as zero, and readback bits 31:8 read as zero.
- R7: The reset control word is at offset 0x200c, with bit 8 for manual mode and bit 0 for release. `phy_reset_n` is high exactly when both bits are 1. The word reads back those two bits only.
- R8: The port-select word is at offset 0x0000, with the field in bits 11:9. The field reads back in place and drives `port_sel`.
- R9: A write to any other offset changes nothing, and a read from any other offset returns zero.
- R10: `bus_rdata` is registered. It carries the read value in the cycle after a read access and is zero after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| phy_reset_n | output | 1 | PHY reset, low = held in reset |
| port_sel | output | PS_W | Port-select field |

## Verification
The assertions assume that a bus access takes exactly one cycle and that a read and a write never share a cycle. The command strobe and the readback strobe therefore never fire together, and a bank cannot change in the same cycle that the readback loads from it. They also assume that reset is applied before the first clock edge. The stimulus drives one access per cycle, or an idle cycle, and only ever changes inputs on the falling clock edge. It holds reset for several cycles at start-up. The random phase draws offsets from the defined set plus two undefined ones, which keeps every access well-formed while varying the write-enable history freely.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

   localparam int unsigned OFS_PORT = 32'h0000;
   localparam int unsigned OFS_CMD  = 32'h2000;
   localparam int unsigned OFS_RB   = 32'h2004;
   localparam int unsigned OFS_RST  = 32'h200c;

   typedef enum logic [2:0] {
      ACC_PORT,
      ACC_CMD,
      ACC_RB,
      ACC_RST,
      ACC_NONE
   } acc_e;

endpackage

// File: rtl/ptb_lane.sv
module ptb_lane #(
   parameter int DAT_W = 8,
   parameter int ADR_W = 5,
   parameter int DEPTH = 32,
   localparam int FIELD_W = DAT_W + ADR_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_wr,
   input  logic [FIELD_W-1:0] cmd_in,
   input  logic               rb_rd,
   output logic [FIELD_W-1:0] cmd_q,
   output logic [DAT_W-1:0]   rb_q
);

   logic             in_we;
   logic [ADR_W-1:0] in_adr;
   logic [DAT_W-1:0] in_dat;
   logic [ADR_W-1:0] cur_adr;
   logic             commit;
   logic             pend_q;
   logic [DAT_W-1:0] bank [DEPTH];

   initial begin
      depth_chk: assert (DEPTH == (1 << ADR_W))
         else $error("bank depth must match index width");
   end

   assign in_we   = cmd_in[0];
   assign in_adr  = cmd_in[ADR_W:1];
   assign in_dat  = cmd_in[FIELD_W-1:ADR_W+1];
   assign cur_adr = cmd_q[ADR_W:1];
   assign commit  = cmd_wr && in_we && !cmd_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (cmd_wr) begin
         cmd_q <= cmd_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
      end else if (commit) begin
         bank[in_adr] <= in_dat;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         rb_q   <= '0;
      end else if (cmd_wr) begin
         pend_q <= 1'b1;
      end else if (rb_rd && pend_q) begin
         pend_q <= 1'b0;
         rb_q   <= bank[cur_adr];
      end
   end

   // R3
   commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && in_we && !cmd_q[0]) |=> bank[$past(in_adr)] == $past(in_dat));

   // R3
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wr |=> $stable(cmd_q));

   // R4
   rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rb_rd && pend_q) |=> $stable(rb_q));

   // R4
   rb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_rd && pend_q && !cmd_wr) |=> (rb_q == bank[$past(cur_adr)]) && !pend_q);

endmodule

// File: rtl/ptb_host_regs.sv
module ptb_host_regs
   import ptb_pkg::*;
#(
   parameter int ADDR_W     = 14,
   parameter int NUM_PHY    = 2,
   parameter int LANE_SHIFT = 16,
   parameter int FIELD_W    = 14,
   parameter int DAT_W      = 8,
   parameter int PS_LSB     = 9,
   parameter int PS_W       = 3,
   parameter int MODE_BIT   = 8,
   parameter int REL_BIT    = 0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                bus_sel,
   input  logic                                bus_wr,
   input  logic [ADDR_W-1:0]                   bus_addr,
   input  logic [31:0]                         bus_wdata,
   input  logic [NUM_PHY-1:0][FIELD_W-1:0]     lane_cmd,
   input  logic [NUM_PHY-1:0][DAT_W-1:0]       lane_rb,
   output logic                                cmd_wr,
   output logic                                rb_rd,
   output logic [31:0]                         bus_rdata,
   output logic                                phy_reset_n,
   output logic [PS_W-1:0]                     port_sel
);

   acc_e        acc;
   logic        rd_acc;
   logic        wr_acc;
   logic [31:0] rd_word;
   logic [PS_W-1:0] ps_q;
   logic        mode_q;
   logic        rel_q;
   logic        unused_wbits;

   assign unused_wbits = ^bus_wdata;

   always_comb begin
      if (bus_addr == ADDR_W'(OFS_PORT))      acc = ACC_PORT;
      else if (bus_addr == ADDR_W'(OFS_CMD))  acc = ACC_CMD;
      else if (bus_addr == ADDR_W'(OFS_RB))   acc = ACC_RB;
      else if (bus_addr == ADDR_W'(OFS_RST))  acc = ACC_RST;
      else                                    acc = ACC_NONE;
   end

   assign wr_acc = bus_sel && bus_wr;
   assign rd_acc = bus_sel && !bus_wr;
   assign cmd_wr = wr_acc && (acc == ACC_CMD);
   assign rb_rd  = rd_acc && (acc == ACC_RB);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ps_q   <= '0;
         mode_q <= 1'b0;
         rel_q  <= 1'b0;
      end else if (wr_acc) begin
         if (acc == ACC_PORT) ps_q <= bus_wdata[PS_LSB +: PS_W];
         if (acc == ACC_RST) begin
            mode_q <= bus_wdata[MODE_BIT];
            rel_q  <= bus_wdata[REL_BIT];
         end
      end
   end

   assign port_sel    = ps_q;
   assign phy_reset_n = mode_q && rel_q;

   always_comb begin
      rd_word = '0;
      case (acc)
         ACC_PORT: rd_word[PS_LSB +: PS_W] = ps_q;
         ACC_CMD: begin
            for (int l = 0; l < NUM_PHY; l++)
               rd_word[l*LANE_SHIFT +: FIELD_W] = lane_cmd[l];
         end
         ACC_RB: begin
            for (int l = 0; l < NUM_PHY; l++)
               rd_word[l*LANE_SHIFT +: DAT_W] = lane_rb[l];
         end
         ACC_RST: begin
            rd_word[MODE_BIT] = mode_q;
            rd_word[REL_BIT]  = rel_q;
         end
         default: rd_word = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_acc ? rd_word : '0;
   end

   // R9
   undef_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && acc == ACC_NONE) |=> bus_rdata == '0);

   // R10
   idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_acc |=> bus_rdata == '0);

   // R7
   mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && acc == ACC_RST && !bus_wdata[MODE_BIT]) |=> !phy_reset_n);

   // R8
   ps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_acc && acc == ACC_PORT) |=> $stable(port_sel));

endmodule

// File: rtl/phy_test_bridge.sv
module phy_test_bridge #(
   parameter int ADDR_W     = 14,
   parameter int NUM_PHY    = 2,
   parameter int LANE_SHIFT = 16,
   parameter int DAT_W      = 8,
   parameter int ADR_W      = 5,
   parameter int PS_LSB     = 9,
   parameter int PS_W       = 3,
   localparam int DEPTH     = 1 << ADR_W,
   localparam int FIELD_W   = DAT_W + ADR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              phy_reset_n,
   output logic [PS_W-1:0]   port_sel
);

   initial begin
      nphy_chk: assert (NUM_PHY >= 1 && NUM_PHY <= 2)
         else $error("NUM_PHY must be 1 or 2");
      lane_fit_chk: assert (FIELD_W <= LANE_SHIFT && NUM_PHY * LANE_SHIFT <= 32)
         else $error("lane fields do not fit the command word");
      addr_fit_chk: assert (ADDR_W >= 14)
         else $error("address too narrow for register offsets");
   end

   logic                            cmd_wr;
   logic                            rb_rd;
   logic [NUM_PHY-1:0][FIELD_W-1:0] lane_cmd;
   logic [NUM_PHY-1:0][DAT_W-1:0]   lane_rb;

   generate
      for (genvar l = 0; l < NUM_PHY; l++) begin : g_lane
         ptb_lane #(
            .DAT_W (DAT_W),
            .ADR_W (ADR_W),
            .DEPTH (DEPTH)
         ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd_wr (cmd_wr),
            .cmd_in (bus_wdata[l*LANE_SHIFT +: FIELD_W]),
            .rb_rd  (rb_rd),
            .cmd_q  (lane_cmd[l]),
            .rb_q   (lane_rb[l])
         );
      end
   endgenerate

   ptb_host_regs #(
      .ADDR_W     (ADDR_W),
      .NUM_PHY    (NUM_PHY),
      .LANE_SHIFT (LANE_SHIFT),
      .FIELD_W    (FIELD_W),
      .DAT_W      (DAT_W),
      .PS_LSB     (PS_LSB),
      .PS_W       (PS_W),
      .MODE_BIT   (8),
      .REL_BIT    (0)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_sel     (bus_sel),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .lane_cmd    (lane_cmd),
      .lane_rb     (lane_rb),
      .cmd_wr      (cmd_wr),
      .rb_rd       (rb_rd),
      .bus_rdata   (bus_rdata),
      .phy_reset_n (phy_reset_n),
      .port_sel    (port_sel)
   );

   // R6
   upper_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rb_rd |=> (bus_rdata[15:8] == 8'h00) && (bus_rdata[31:24] == 8'h00));

endmodule

// File: tb/phy_test_bridge_tb.sv
module phy_test_bridge_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [13:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata [2];
   logic        rstn_o [2];
   logic [2:0]  ps_o [2];

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string phase = "R1";

   logic [7:0]  m_bank [2][2][32];
   logic [13:0] m_cmd  [2][2];
   logic [7:0]  m_rb   [2][2];
   bit          m_pend [2][2];
   logic [2:0]  m_ps   [2];
   bit          m_man  [2];
   bit          m_rel  [2];
   logic [31:0] e_rdata [2];

   always #10 clk = ~clk;

   phy_test_bridge #(.NUM_PHY(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata[0]),
      .phy_reset_n(rstn_o[0]), .port_sel(ps_o[0]));

   phy_test_bridge #(.NUM_PHY(1)) u_dut_s (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata[1]),
      .phy_reset_n(rstn_o[1]), .port_sel(ps_o[1]));

   function automatic logic [13:0] fld(int adr, int dat, bit we);
      return {8'(dat), 5'(adr), we};
   endfunction

   task automatic model_init();
      for (int d = 0; d < 2; d++) begin
         for (int l = 0; l < 2; l++) begin
            for (int a = 0; a < 32; a++) m_bank[d][l][a] = '0;
            m_cmd[d][l] = '0; m_rb[d][l] = '0; m_pend[d][l] = 0;
         end
         m_ps[d] = '0; m_man[d] = 0; m_rel[d] = 0; e_rdata[d] = '0;
      end
   endtask

   task automatic model_step(bit s, bit w, logic [13:0] a, logic [31:0] wd);
      for (int d = 0; d < 2; d++) begin
         int np = (d == 0) ? 2 : 1;
         e_rdata[d] = '0;
         if (s && w) begin
            if (a == 14'h0000) m_ps[d] = wd[11:9];
            else if (a == 14'h200c) begin m_man[d] = wd[8]; m_rel[d] = wd[0]; end
            else if (a == 14'h2000) begin
               for (int l = 0; l < np; l++) begin
                  logic [13:0] f = wd[l*16 +: 14];
                  if (f[0] && !m_cmd[d][l][0]) m_bank[d][l][f[5:1]] = f[13:6];
                  m_cmd[d][l] = f;
                  m_pend[d][l] = 1;
               end
            end
         end else if (s && !w) begin
            if (a == 14'h0000) e_rdata[d][11:9] = m_ps[d];
            else if (a == 14'h200c) begin e_rdata[d][8] = m_man[d]; e_rdata[d][0] = m_rel[d]; end
            else if (a == 14'h2000) begin
               for (int l = 0; l < np; l++) e_rdata[d][l*16 +: 14] = m_cmd[d][l];
            end else if (a == 14'h2004) begin
               for (int l = 0; l < np; l++) begin
                  e_rdata[d][l*16 +: 8] = m_rb[d][l];
                  if (m_pend[d][l]) begin
                     m_rb[d][l] = m_bank[d][l][m_cmd[d][l][5:1]];
                     m_pend[d][l] = 0;
                  end
               end
            end
         end
      end
   endtask

   task automatic compare();
      for (int d = 0; d < 2; d++) begin
         checks++;
         if (rdata[d] !== e_rdata[d]) begin
            errors++;
            $display("FAIL %s dut%0d bus_rdata: actual %h expected %h", phase, d, rdata[d], e_rdata[d]);
         end
         checks++;
         if (rstn_o[d] !== (m_man[d] && m_rel[d])) begin
            errors++;
            $display("FAIL %s/R7 dut%0d phy_reset_n: actual %b expected %b", phase, d, rstn_o[d], m_man[d] && m_rel[d]);
         end
         checks++;
         if (ps_o[d] !== m_ps[d]) begin
            errors++;
            $display("FAIL %s/R8 dut%0d port_sel: actual %h expected %h", phase, d, ps_o[d], m_ps[d]);
         end
      end
   endtask

   task automatic cyc(bit s, bit w, logic [13:0] a, logic [31:0] wd);
      @(negedge clk);
      compare();
      bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = wd;
      model_step(s, w, a, wd);
   endtask

   task automatic wr(logic [13:0] a, logic [31:0] wd); cyc(1, 1, a, wd); endtask
   task automatic rd(logic [13:0] a); cyc(1, 0, a, '0); endtask
   task automatic idle(); cyc(0, 0, '0, '0); endtask

   task automatic commit3(logic [31:0] v);
      wr(14'h2000, v);
      wr(14'h2000, v | 32'h0001_0001);
      wr(14'h2000, v & ~32'h0001_0001);
   endtask

   initial begin
      model_init();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      phase = "R1";
      rd(14'h0000); rd(14'h2000); rd(14'h2004); rd(14'h200c); idle();

      phase = "R8";
      wr(14'h0000, 32'hffff_ffff); rd(14'h0000);
      wr(14'h0000, 32'h0000_0200); rd(14'h0000);

      phase = "R7";
      wr(14'h200c, 32'h0000_0101); rd(14'h200c);
      wr(14'h200c, 32'h0000_0001); idle();
      wr(14'h200c, 32'h0000_0100); idle();
      wr(14'h200c, 32'hffff_ffff); rd(14'h200c);

      phase = "R2";
      wr(14'h2000, {18'h0, fld(7, 8'h3c, 0)}); rd(14'h2000);

      phase = "R3";
      commit3({2'b0, fld(26, 8'h50, 0), 2'b0, fld(26, 8'h50, 0)});
      rd(14'h2004); rd(14'h2004); rd(14'h2004);
      wr(14'h2000, {18'h0, fld(5, 8'haa, 0)});
      wr(14'h2000, {18'h0, fld(5, 8'haa, 1)});
      wr(14'h2000, {18'h0, fld(5, 8'h55, 1)});
      wr(14'h2000, {18'h0, fld(5, 8'h55, 0)});
      rd(14'h2004); rd(14'h2004);

      phase = "R4";
      wr(14'h2000, {18'h0, fld(26, 8'h01, 0)});
      rd(14'h2004); idle(); rd(14'h2004);
      wr(14'h2000, {18'h0, fld(0, 8'h01, 0)});
      rd(14'h0000); rd(14'h2004); rd(14'h2004);

      phase = "R5";
      commit3({2'b0, fld(28, 8'hc3, 0), 2'b0, fld(28, 8'h0f, 0)});
      wr(14'h2000, {2'b0, fld(28, 8'h01, 0), 2'b0, fld(26, 8'h01, 0)});
      rd(14'h2004); rd(14'h2004); rd(14'h2000);

      phase = "R6";
      wr(14'h2000, 32'hffff_c000); rd(14'h2000); rd(14'h2004); rd(14'h2004);

      phase = "R9";
      wr(14'h2008, 32'hffff_ffff); wr(14'h1000, 32'hffff_ffff);
      rd(14'h2008); rd(14'h1000); rd(14'h0000); rd(14'h200c); rd(14'h2000);

      phase = "R10";
      rd(14'h200c); idle(); idle();

      phase = "R5";
      for (int i = 0; i < 400; i++) begin
         int k = $urandom_range(0, 5);
         logic [13:0] a;
         case (k)
            0: a = 14'h0000; 1: a = 14'h2000; 2: a = 14'h2004;
            3: a = 14'h200c; 4: a = 14'h2008; default: a = 14'h0ffc;
         endcase
         cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), a, $urandom());
      end
      idle(); idle();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule